// File: doc/BRIEF.md
# Swizzled Source Operand Fetch Unit

This unit produces one four-lane operand per request for a vector instruction pipeline. The request carries a 128-bit instruction, split into four 32-bit words, and a selector naming which of the three source slots to fetch. The bits that describe each slot are not contiguous: for two of the slots they are spread across two words. Once the 17-bit descriptor is gathered, its type field steers the read to the temporary register file, the current input attribute or the constant memory. The temporary and input files arrive as flat vectors, and the constant memory sits behind a zero-latency read port.

A constant can be addressed relative to an address register. In that case one signed lane of one of two address registers is added to the base index from the instruction, and any sum that falls outside the constant memory yields zero. The fetched vector then passes through a lane reordering step, an optional magnitude step and an optional sign flip. The result, in 16-bit signed lanes, is registered one clock after the request.

Top module: `srcop_fetch`

## Requirements
- R1: `out_valid` is high in exactly the cycle after each cycle with `req_valid` high. `op_data` takes the new operand on that edge and holds its value while no request is made. Reset clears both.
- R2: The descriptor for `req_sel` 0 is {w1[7:0], w2[31:23]}. For `req_sel` 1 it is w2[22:6], and for `req_sel` 2 it is {w2[5:0], w3[31:21]}. `req_sel` 3 yields an all-zero operand.
- R3: Within a descriptor, bit 16 is negate, [15:8] is the swizzle, [7:2] is the temporary index and [1:0] is the kind: 1 = temporary, 2 = input attribute, 3 = constant. Kind 0 yields an all-zero operand.
- R4: A temporary read returns entry [7:2] of `temp_file`, or zero when that index is NUM_TEMP or above. Each vector packs lane x in bits [15:0], y in [31:16], z in [47:32] and w in [63:48], and entry i occupies bits [64i+63:64i].
- R5: An input read returns the attribute indexed by w1[11:8].
- R6: A direct constant read uses w1[21:12] as the index, and an index of CONST_DEPTH or more yields zero.
- R7: When w3[1] is set, the constant index is w1[21:12] plus a signed lane of an address register. w0[24] picks the register, and w0[1:0] picks the lane (0 = x … 3 = w). A sum below 0 or at CONST_DEPTH or above yields zero.
- R8: Lane selector values 0..3 stand for x..w. Output x takes the lane named by swizzle [7:6], y by [5:4], z by [3:2] and w by [1:0]. Swizzle 0x1B passes the vector through unchanged.
- R9: The magnitude flag for source s is w0[21+s]. The magnitude step is applied before negation.
- R10: Both the magnitude step and negation saturate, so the most negative lane value -32768 becomes 32767.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Fetch request |
| req_sel | input | 2 | Source slot to fetch (0..2) |
| instr_w0 | input | 32 | Instruction word 0 |
| instr_w1 | input | 32 | Instruction word 1 |
| instr_w2 | input | 32 | Instruction word 2 |
| instr_w3 | input | 32 | Instruction word 3 |
| temp_file | input | NUM_TEMP*64 | Flat temporary register file |
| in_attrs | input | NUM_INPUT*64 | Flat input attribute file |
| addr_regs | input | 128 | Two address registers, four signed lanes each |
| cmem_addr | output | 9 | Constant memory read address |
| cmem_data | input | 64 | Constant memory read data, same cycle |
| out_valid | output | 1 | Operand valid |
| op_data | output | 64 | Registered four-lane operand |

## Verification
The assertions assume that the constant memory answers `cmem_addr` within the same cycle and that the instruction words and selector stay stable from one falling clock edge to the next. They also assume that `req_valid` is held low while reset is active. The bench keeps to these conditions: it models the constant memory as a combinational array read and changes every input only on falling edges. Background bit patterns fill the fields of the unselected slots and the opposite magnitude flags, so a fetch from the wrong slot produces a visibly wrong operand.

// File: rtl/srcop_pkg.sv
package srcop_pkg;

   typedef enum logic [1:0] {
      KIND_NONE  = 2'd0,
      KIND_TEMP  = 2'd1,
      KIND_INPUT = 2'd2,
      KIND_CONST = 2'd3
   } src_kind_e;

   typedef struct packed {
      logic       neg;
      logic [7:0] swz;
      logic [5:0] idx;
      src_kind_e  kind;
   } src_desc_t;

   localparam int DESC_W       = 17;
   localparam logic [7:0] SWZ_IDENTITY = 8'h1B;
   localparam int ABS_LSB      = 21;
   localparam int AREG_SEL_BIT = 24;
   localparam int REL_BIT      = 1;
   localparam int CBASE_LSB    = 12;
   localparam int CBASE_W      = 10;
   localparam int INIDX_LSB    = 8;
   localparam int INIDX_W      = 4;
   localparam int TIDX_W       = 6;

endpackage

// File: rtl/srcop_desc_unpack.sv
module srcop_desc_unpack
   import srcop_pkg::*;
(
   input  logic [DESC_W-1:0] src0,
   input  logic [DESC_W-1:0] src1,
   input  logic [DESC_W-1:0] src2,
   input  logic [2:0]        abs_flags,
   input  logic [1:0]        sel,
   output src_desc_t         desc,
   output logic              abs_en
);
   logic [DESC_W-1:0] raw;

   always_comb begin
      raw    = '0;
      abs_en = 1'b0;
      case (sel)
         2'd0: begin raw = src0; abs_en = abs_flags[0]; end
         2'd1: begin raw = src1; abs_en = abs_flags[1]; end
         2'd2: begin raw = src2; abs_en = abs_flags[2]; end
         default: begin raw = '0; abs_en = 1'b0; end
      endcase
   end

   assign desc = src_desc_t'(raw);
endmodule

// File: rtl/srcop_const_addr.sv
module srcop_const_addr
   import srcop_pkg::*;
#(
   parameter int LANE_W      = 16,
   parameter int CONST_DEPTH = 512
)(
   input  logic [CBASE_W-1:0]             base,
   input  logic                           rel_en,
   input  logic [2*4*LANE_W-1:0]          addr_regs,
   input  logic                           reg_sel,
   input  logic [1:0]                     lane_sel,
   output logic [$clog2(CONST_DEPTH)-1:0] addr,
   output logic                           in_range
);
   localparam int CONST_AW = $clog2(CONST_DEPTH);
   localparam int SUM_W    = ((LANE_W > CBASE_W) ? LANE_W : CBASE_W) + 2;

   logic signed [LANE_W-1:0] offset;
   logic signed [SUM_W-1:0]  sum;

   always_comb begin
      offset = '0;
      if (rel_en)
         offset = addr_regs[(int'(reg_sel) * 4 + int'(lane_sel)) * LANE_W +: LANE_W];
      sum      = $signed({{(SUM_W-CBASE_W){1'b0}}, base}) + SUM_W'(offset);
      in_range = !sum[SUM_W-1] && (sum < SUM_W'(CONST_DEPTH));
      addr     = sum[CONST_AW-1:0];
   end
endmodule

// File: rtl/srcop_reg_select.sv
module srcop_reg_select
   import srcop_pkg::*;
#(
   parameter int LANE_W    = 16,
   parameter int NUM_TEMP  = 32,
   parameter int NUM_INPUT = 16
)(
   input  src_kind_e                   kind,
   input  logic [TIDX_W-1:0]           idx,
   input  logic [INIDX_W-1:0]          in_idx,
   input  logic [NUM_TEMP*4*LANE_W-1:0]  temp_file,
   input  logic [NUM_INPUT*4*LANE_W-1:0] in_attrs,
   input  logic [4*LANE_W-1:0]         cmem_data,
   input  logic                        const_ok,
   output logic [4*LANE_W-1:0]         vec
);
   localparam int VEC_W = 4 * LANE_W;
   localparam int TAW   = $clog2(NUM_TEMP);
   localparam int IAW   = $clog2(NUM_INPUT);

   logic temp_ok;
   logic in_ok;

   generate
      if (NUM_TEMP >= (1 << TIDX_W)) begin : g_temp_full
         assign temp_ok = 1'b1;
      end else begin : g_temp_part
         assign temp_ok = (idx < TIDX_W'(NUM_TEMP));
      end
      if (NUM_INPUT >= (1 << INIDX_W)) begin : g_in_full
         assign in_ok = 1'b1;
      end else begin : g_in_part
         assign in_ok = (in_idx < INIDX_W'(NUM_INPUT));
      end
   endgenerate

   always_comb begin
      vec = '0;
      case (kind)
         KIND_TEMP:  if (temp_ok)  vec = temp_file[int'(idx[TAW-1:0]) * VEC_W +: VEC_W];
         KIND_INPUT: if (in_ok)    vec = in_attrs[int'(in_idx[IAW-1:0]) * VEC_W +: VEC_W];
         KIND_CONST: if (const_ok) vec = cmem_data;
         default:    vec = '0;
      endcase
   end
endmodule

// File: rtl/srcop_lane_mod.sv
module srcop_lane_mod
   import srcop_pkg::*;
#(
   parameter int LANE_W = 16
)(
   input  logic [4*LANE_W-1:0] vec,
   input  logic [7:0]          swz,
   input  logic                abs_en,
   input  logic                neg,
   output logic [4*LANE_W-1:0] res
);
   localparam logic [LANE_W-1:0] LANE_MIN = {1'b1, {(LANE_W-1){1'b0}}};
   localparam logic [LANE_W-1:0] LANE_MAX = {1'b0, {(LANE_W-1){1'b1}}};

   function automatic logic [LANE_W-1:0] sat_neg(input logic [LANE_W-1:0] v);
      if (v == LANE_MIN) return LANE_MAX;
      return -v;
   endfunction

   logic [LANE_W-1:0] src_l [4];
   logic              bypass;

   assign bypass = (swz == SWZ_IDENTITY);

   generate
      for (genvar l = 0; l < 4; l++) begin : g_lane
         logic [1:0]        pick;
         logic [LANE_W-1:0] picked;
         logic [LANE_W-1:0] mag;

         assign src_l[l] = vec[l*LANE_W +: LANE_W];
         assign pick     = bypass ? 2'(l) : swz[7-2*l -: 2];
         assign picked   = src_l[pick];
         assign mag      = (abs_en && picked[LANE_W-1]) ? sat_neg(picked) : picked;
         assign res[l*LANE_W +: LANE_W] = neg ? sat_neg(mag) : mag;
      end
   endgenerate
endmodule

// File: rtl/srcop_fetch.sv
module srcop_fetch
   import srcop_pkg::*;
#(
   parameter int LANE_W      = 16,
   parameter int NUM_TEMP    = 32,
   parameter int NUM_INPUT   = 16,
   parameter int CONST_DEPTH = 512
)(
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            req_valid,
   input  logic [1:0]                      req_sel,
   input  logic [31:0]                     instr_w0,
   input  logic [31:0]                     instr_w1,
   input  logic [31:0]                     instr_w2,
   input  logic [31:0]                     instr_w3,
   input  logic [NUM_TEMP*4*LANE_W-1:0]    temp_file,
   input  logic [NUM_INPUT*4*LANE_W-1:0]   in_attrs,
   input  logic [2*4*LANE_W-1:0]           addr_regs,
   output logic [$clog2(CONST_DEPTH)-1:0]  cmem_addr,
   input  logic [4*LANE_W-1:0]             cmem_data,
   output logic                            out_valid,
   output logic [4*LANE_W-1:0]             op_data
);
   localparam int VEC_W = 4 * LANE_W;

   generate
      if (LANE_W < 4)
         $error("LANE_W must be at least 4");
      if (NUM_TEMP < 2 || NUM_TEMP > 64 || (NUM_TEMP & (NUM_TEMP - 1)) != 0)
         $error("NUM_TEMP must be a power of two in 2..64");
      if (NUM_INPUT < 2 || NUM_INPUT > 16 || (NUM_INPUT & (NUM_INPUT - 1)) != 0)
         $error("NUM_INPUT must be a power of two in 2..16");
      if (CONST_DEPTH < 2 || (CONST_DEPTH & (CONST_DEPTH - 1)) != 0)
         $error("CONST_DEPTH must be a power of two of at least 2");
   endgenerate

   src_desc_t         src_desc;
   logic              src_abs;
   logic              const_ok;
   logic [VEC_W-1:0]  raw_vec;
   logic [VEC_W-1:0]  mod_vec;
   logic              unused_bits;

   assign unused_bits = ^{instr_w0[31:25], instr_w0[20:2], instr_w1[31:22],
                          instr_w3[20:2], instr_w3[0]};

   srcop_desc_unpack u_unpack (
      .src0      ({instr_w1[7:0], instr_w2[31:23]}),
      .src1      (instr_w2[22:6]),
      .src2      ({instr_w2[5:0], instr_w3[31:21]}),
      .abs_flags (instr_w0[ABS_LSB +: 3]),
      .sel       (req_sel),
      .desc      (src_desc),
      .abs_en    (src_abs)
   );

   srcop_const_addr #(
      .LANE_W      (LANE_W),
      .CONST_DEPTH (CONST_DEPTH)
   ) u_caddr (
      .base      (instr_w1[CBASE_LSB +: CBASE_W]),
      .rel_en    (instr_w3[REL_BIT]),
      .addr_regs (addr_regs),
      .reg_sel   (instr_w0[AREG_SEL_BIT]),
      .lane_sel  (instr_w0[1:0]),
      .addr      (cmem_addr),
      .in_range  (const_ok)
   );

   srcop_reg_select #(
      .LANE_W    (LANE_W),
      .NUM_TEMP  (NUM_TEMP),
      .NUM_INPUT (NUM_INPUT)
   ) u_rsel (
      .kind      (src_desc.kind),
      .idx       (src_desc.idx),
      .in_idx    (instr_w1[INIDX_LSB +: INIDX_W]),
      .temp_file (temp_file),
      .in_attrs  (in_attrs),
      .cmem_data (cmem_data),
      .const_ok  (const_ok),
      .vec       (raw_vec)
   );

   srcop_lane_mod #(
      .LANE_W (LANE_W)
   ) u_lmod (
      .vec    (raw_vec),
      .swz    (src_desc.swz),
      .abs_en (src_abs),
      .neg    (src_desc.neg),
      .res    (mod_vec)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         op_data   <= '0;
      end else begin
         out_valid <= req_valid;
         if (req_valid)
            op_data <= mod_vec;
      end
   end
endmodule

// File: rtl/srcop_fetch_chk.sv
module srcop_fetch_chk #(
   parameter int LANE_W = 16
)(
   input logic                clk,
   input logic                rst_n,
   input logic                req_valid,
   input logic                out_valid,
   input logic [4*LANE_W-1:0] op_data,
   input logic [16:0]         desc_bits,
   input logic                abs_en,
   input logic                const_ok
);
   logic       armed;
   logic [3:0] lane_sign;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   always_comb begin
      for (int l = 0; l < 4; l++)
         lane_sign[l] = op_data[l*LANE_W + LANE_W - 1];
   end

   a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      out_valid == $past(req_valid));

   a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      !$past(req_valid) |-> $stable(op_data));

   a_r3_none_zero: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(req_valid && desc_bits[1:0] == 2'd0) |-> op_data == '0);

   a_r7_const_oob_zero: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(req_valid && desc_bits[1:0] == 2'd3 && !const_ok) |-> op_data == '0);

   a_r9_abs_nonneg: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      $past(req_valid && abs_en && !desc_bits[16]) |-> lane_sign == 4'b0000);
endmodule

bind srcop_fetch srcop_fetch_chk #(.LANE_W(LANE_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_valid (req_valid),
   .out_valid (out_valid),
   .op_data   (op_data),
   .desc_bits (src_desc),
   .abs_en    (src_abs),
   .const_ok  (const_ok)
);

// File: tb/srcop_fetch_tb_top.sv
module srcop_fetch_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NT = 32;
   localparam int NI = 16;
   localparam int ND = 512;

   typedef struct {
      logic [63:0] data;
      string       tag;
   } exp_t;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              req_valid;
   logic [1:0]        req_sel;
   logic [31:0]       w0, w1, w2, w3;
   logic [NT*64-1:0]  temp_file;
   logic [NI*64-1:0]  in_attrs;
   logic [127:0]      addr_regs;
   logic [8:0]        cmem_addr;
   logic [63:0]       cmem_data;
   logic              out_valid;
   logic [63:0]       op_data;

   logic [63:0]        tvec [NT];
   logic [63:0]        ivec [NI];
   logic [63:0]        cmem [ND];
   logic signed [15:0] areg [2][4];

   exp_t        exp_q [$];
   exp_t        cur;
   logic [63:0] last_exp;
   int          n_chk = 0;
   int          n_fail = 0;
   logic        done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   srcop_fetch dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_sel(req_sel),
      .instr_w0(w0), .instr_w1(w1), .instr_w2(w2), .instr_w3(w3),
      .temp_file(temp_file), .in_attrs(in_attrs), .addr_regs(addr_regs),
      .cmem_addr(cmem_addr), .cmem_data(cmem_data),
      .out_valid(out_valid), .op_data(op_data)
   );

   assign cmem_data = cmem[cmem_addr];

   always_comb begin
      for (int i = 0; i < NT; i++) temp_file[i*64 +: 64] = tvec[i];
      for (int i = 0; i < NI; i++) in_attrs[i*64 +: 64] = ivec[i];
      for (int r = 0; r < 2; r++)
         for (int l = 0; l < 4; l++) addr_regs[(r*4+l)*16 +: 16] = areg[r][l];
   end

   function automatic logic [15:0] clamp16(input int x);
      if (x > 32767) return 16'sd32767;
      if (x < -32768) return 16'h8000;
      return 16'(x);
   endfunction

   function automatic logic [63:0] model(input logic [31:0] a, input logic [31:0] b,
                                         input logic [31:0] c, input logic [31:0] e,
                                         input logic [1:0] sel);
      logic [16:0] d;
      logic        ab;
      logic [63:0] v;
      logic [63:0] r;
      int          idx;
      case (sel)
         2'd0: d = {b[7:0], c[31:23]};
         2'd1: d = c[22:6];
         2'd2: d = {c[5:0], e[31:21]};
         default: return 64'd0;
      endcase
      ab = a[21 + int'(sel)];
      v = 64'd0;
      case (d[1:0])
         2'd0: return 64'd0;
         2'd1: if (int'(d[7:2]) < NT) v = tvec[d[7:2]];
         2'd2: v = ivec[b[11:8]];
         default: begin
            idx = int'(b[21:12]);
            if (e[1]) idx += int'(areg[a[24]][a[1:0]]);
            if (idx >= 0 && idx < ND) v = cmem[idx];
         end
      endcase
      for (int l = 0; l < 4; l++) begin
         int pick;
         int x;
         pick = (d[15:8] == 8'h1B) ? l : int'(d[15-2*l -: 2]);
         x = int'($signed(v[pick*16 +: 16]));
         if (ab && x < 0) x = -x;
         if (d[16]) x = -clamp16(x) == 0 ? 0 : -int'($signed(clamp16(x)));
         r[l*16 +: 16] = clamp16(x);
      end
      return r;
   endfunction

   function automatic logic [16:0] mkd(input logic ng, input logic [7:0] sw,
                                       input logic [5:0] ix, input logic [1:0] k);
      return {ng, sw, ix, k};
   endfunction

   task automatic check(input logic [63:0] got, input logic [63:0] expv, input string tag);
      n_chk++;
      if (got !== expv) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, expv);
      end
   endtask

   task automatic issue(input int sel, input logic [16:0] d, input logic ab,
                        input logic [9:0] cbase, input logic [3:0] iidx, input logic rel,
                        input logic ar, input logic [1:0] al, input string tag);
      logic [31:0] a, b, c, e;
      exp_t item;
      a = 32'h5A3C_96E1; b = 32'hC3A5_1F0E; c = 32'h6B2D_E479; e = 32'h9E17_B3C5;
      case (sel)
         0: {b[7:0], c[31:23]} = d;
         1: c[22:6] = d;
         2: {c[5:0], e[31:21]} = d;
         default: ;
      endcase
      a[23:21] = {3{~ab}};
      if (sel < 3) a[21 + sel] = ab;
      a[1:0] = al; a[24] = ar;
      b[11:8] = iidx; b[21:12] = cbase; e[1] = rel;
      @(negedge clk);
      w0 = a; w1 = b; w2 = c; w3 = e;
      req_sel = 2'(sel);
      req_valid = 1'b1;
      item.data = model(a, b, c, e, 2'(sel));
      item.tag = tag;
      exp_q.push_back(item);
      last_exp = item.data;
   endtask

   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL R1: valid without request, got %h expected none", op_data);
         end else begin
            cur = exp_q.pop_front();
            check(op_data, cur.data, cur.tag);
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL R1: watchdog expired, got running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < NT; i++)
         for (int l = 0; l < 4; l++) tvec[i][l*16 +: 16] = 16'(i*997 + l*4093 - 15000);
      tvec[5][31:16] = 16'h8000;
      tvec[5][15:0]  = 16'h0123;
      for (int i = 0; i < NI; i++)
         for (int l = 0; l < 4; l++) ivec[i][l*16 +: 16] = 16'(i*301 - l*2222 + 77);
      for (int i = 0; i < ND; i++)
         for (int l = 0; l < 4; l++) cmem[i][l*16 +: 16] = 16'(i*3 + l*1000 - 1500);
      areg[0][0] = 16'sd5;   areg[0][1] = -16'sd3; areg[0][2] = 16'sd600; areg[0][3] = -16'sd10;
      areg[1][0] = 16'sd100; areg[1][1] = -16'sd200; areg[1][2] = 16'sd20; areg[1][3] = 16'sd700;

      rst_n = 1'b0; req_valid = 1'b0; req_sel = 2'd0;
      w0 = '0; w1 = '0; w2 = '0; w3 = '0;
      repeat (3) @(negedge clk);
      n_chk++; if (out_valid !== 1'b0) begin n_fail++; $display("FAIL R1: reset valid got %b expected 0", out_valid); end
      check(op_data, 64'd0, "R1 reset data");
      rst_n = 1'b1;
      @(negedge clk);

      issue(0, mkd(0, 8'h1B, 6'd3,  2'd1), 0, 10'd0,   4'd0, 0, 0, 2'd0, "R2 R4 R8 slot0 temp identity");
      issue(1, mkd(0, 8'hE4, 6'd7,  2'd1), 0, 10'd0,   4'd0, 0, 0, 2'd0, "R2 R8 slot1 temp straight swizzle");
      issue(2, mkd(0, 8'h00, 6'd9,  2'd1), 0, 10'd0,   4'd0, 0, 0, 2'd0, "R2 R8 slot2 broadcast x");
      issue(1, mkd(0, 8'h1B, 6'd9,  2'd1), 0, 10'd0,   4'd0, 0, 0, 2'd0, "R8 identity after broadcast");
      issue(2, mkd(0, 8'h1B, 6'd0,  2'd2), 0, 10'd0,   4'd6, 0, 0, 2'd0, "R5 input attribute");
      issue(0, mkd(0, 8'h4E, 6'd0,  2'd2), 0, 10'd0,   4'd15, 0, 0, 2'd0, "R5 R8 input last swizzled");
      issue(1, mkd(0, 8'h1B, 6'd0,  2'd3), 0, 10'd20,  4'd0, 0, 0, 2'd0, "R6 constant direct");
      issue(2, mkd(0, 8'h1B, 6'd0,  2'd3), 0, 10'd1000, 4'd0, 0, 0, 2'd0, "R6 constant direct out of range");
      issue(0, mkd(0, 8'h1B, 6'd0,  2'd3), 0, 10'd10,  4'd0, 1, 1, 2'd2, "R7 relative positive");
      issue(1, mkd(0, 8'h1B, 6'd0,  2'd3), 0, 10'd2,   4'd0, 1, 0, 2'd1, "R7 relative below zero");
      issue(2, mkd(0, 8'h1B, 6'd0,  2'd3), 0, 10'd500, 4'd0, 1, 1, 2'd3, "R7 relative beyond depth");
      issue(0, mkd(0, 8'h1B, 6'd0,  2'd3), 0, 10'd511, 4'd0, 1, 0, 2'd3, "R7 relative negative in range");
      issue(1, mkd(0, 8'h1B, 6'd40, 2'd1), 0, 10'd0,   4'd0, 0, 0, 2'd0, "R4 temp index beyond file");
      issue(2, mkd(1, 8'h1B, 6'd3,  2'd0), 1, 10'd0,   4'd0, 0, 0, 2'd0, "R3 kind zero");
      issue(3, mkd(0, 8'h1B, 6'd3,  2'd1), 0, 10'd0,   4'd0, 0, 0, 2'd0, "R2 selector three");
      issue(0, mkd(0, 8'h1B, 6'd5,  2'd1), 1, 10'd0,   4'd0, 0, 0, 2'd0, "R9 R10 magnitude only");
      issue(1, mkd(1, 8'h1B, 6'd5,  2'd1), 0, 10'd0,   4'd0, 0, 0, 2'd0, "R3 R10 negate only");
      issue(2, mkd(1, 8'hE4, 6'd5,  2'd1), 1, 10'd0,   4'd0, 0, 0, 2'd0, "R9 magnitude before negate");

      @(negedge clk);
      req_valid = 1'b0;
      w0 = 32'hFFFF_FFFF; w1 = 32'hFFFF_FFFF; w2 = 32'hFFFF_FFFF; w3 = 32'hFFFF_FFFF;
      repeat (3) @(negedge clk);
      n_chk++; if (out_valid !== 1'b0) begin n_fail++; $display("FAIL R1: idle valid got %b expected 0", out_valid); end
      check(op_data, last_exp, "R1 hold while idle");
      n_chk++;
      if (exp_q.size() != 0) begin
         n_fail++;
         $display("FAIL R1: pending results got %0d expected 0", exp_q.size());
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule